// File: doc/BRIEF.md
# Word-addressed SRAM with a Wishbone slave port

This block is a small single-port memory of 32-bit words behind a Wishbone slave port. Each transfer carries one word address. Reads return the addressed word in a register, and that data is presented in the same cycle as the acknowledge. Writes commit on the accepting clock edge, one byte lane per select bit.

A parameter picks one of two handshake styles.

- **Classic style:** every transfer spans two clocks. The response logic refuses a new request in the cycle where it is acknowledging. A master that keeps strobe high into that cycle therefore never receives a second acknowledge for the same transfer. The stall output carries a bridge for a pipelined master attached to this classic port: it is high while the cycle is open and not yet acknowledged.
- **Pipelined style:** the stall output is held low. Requests are accepted every clock and acknowledged one clock later, with no wait state.

A stall-injection input is intended for benches that need back-pressure. It stalls the port and blocks acceptance in either style.

The response logic is a two-state machine. **IDLE** means no acknowledge is pending. **RESP** means the acknowledge is being driven this cycle. The transitions are:

- **IDLE→RESP** on an accepted request.
- **RESP→IDLE** with no new request accepted. In classic style this always happens, because acceptance is barred in RESP.
- **RESP→RESP** on an accepted back-to-back request. This is possible only in pipelined style.
- **IDLE→IDLE** when nothing is accepted.

Top module: `wb_sram_slave`

## Requirements
- R1: After reset the acknowledge is low, and with cyc low the stall output is low, in both styles.
- R2: Classic style: a request presented with stall injection low is acknowledged in the following cycle. A read's acknowledge carries the word last written to that address on the read-data port.
- R3: Classic style: the acknowledge is never high in two consecutive cycles, even while strobe stays high. A strobe held for four cycles yields acknowledges in cycles 1 and 3 only.
- R4: Classic style: the stall output is high while cyc is high and no acknowledge is present, and it is low in the acknowledge cycle.
- R5: On an accepted write, select bit i enables data bits 8i+7 to 8i. Lanes with a clear select bit keep their old contents.
- R6: Pipelined style: the stall output equals the stall-injection input and is otherwise low.
- R7: Pipelined style: each accepted request (cyc, stb, and stall low) is acknowledged exactly one cycle later. Back-to-back requests get acknowledges on consecutive cycles, in order, with read data matching.
- R8: While stall injection is high, no request is accepted in either style: no acknowledge follows, and a write is not committed.
- R9: A write is committed at its accepting edge, so a read accepted on the very next cycle returns the new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cyc | input | 1 | Bus cycle open |
| wb_stb | input | 1 | Request strobe |
| wb_we | input | 1 | 1 = write, 0 = read |
| wb_adr | input | ADDR_W | Word address |
| wb_dat_w | input | DATA_W | Write data |
| wb_sel | input | DATA_W/8 | Byte-lane enables, bit i for bits 8i+7:8i |
| stall_inject | input | 1 | Test back-pressure; blocks acceptance |
| wb_ack | output | 1 | Registered acknowledge |
| wb_dat_r | output | DATA_W | Registered read data, valid with wb_ack |
| wb_stall | output | 1 | Classic: cyc AND NOT ack; pipelined: stall_inject |

## Verification
The bench targets the duplicate acknowledge. It holds strobe across four classic cycles and expects exactly two acknowledges with a gap between them. A design that acknowledged on consecutive cycles would hand a classic master a phantom second transfer.

It sends back-to-back pipelined reads and a write immediately followed by a read of the same word. A design with an extra wait state would shift every acknowledge. A design that wrote late would return stale data.

Partial byte selects catch lane swaps or whole-word writes. Injected stalls in both styles catch a design that accepts, or commits a write, under back-pressure. The bridge stall is checked both before and at the acknowledge, because a stuck stall would hang a pipelined master.

// File: rtl/sram_wb_pkg.sv
package sram_wb_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } resp_state_e;
endpackage

// File: rtl/sram_word_array.sv
module sram_word_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    localparam int SEL_W = DATA_W / 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              we,
    input  logic [ADDR_W-1:0] adr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    // storage: lane-gated write on the accepting edge
    always_ff @(posedge clk) begin
        if (accept && we) begin
            for (int lane = 0; lane < SEL_W; lane++) begin
                if (sel[lane]) begin
                    store[adr][lane*8 +: 8] <= wdata[lane*8 +: 8];
                end
            end
        end
    end

    // registered read word, presented alongside the acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (accept && !we) begin
            rdata <= store[adr];
        end
    end
endmodule

// File: rtl/sram_stall_gen.sv
module sram_stall_gen #(
    parameter bit PIPELINED = 1'b0
) (
    input  logic cyc,
    input  logic ack,
    input  logic inject,
    output logic stall
);
    generate
        if (PIPELINED) begin : g_pipe
            // a directly pipelined slave never back-pressures by itself
            assign stall = inject;
        end else begin : g_bridge
            // pipelined master on a classic slave: hold off until acknowledged
            assign stall = cyc & ~ack;
        end
    endgenerate
endmodule

// File: rtl/sram_resp_fsm.sv
module sram_resp_fsm
    import sram_wb_pkg::*;
#(
    parameter bit PIPELINED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc,
    input  logic stb,
    input  logic inject,
    output logic accept,
    output logic ack
);
    resp_state_e state_q, state_d;

    // acceptance: classic style refuses while acknowledging
    always_comb begin
        accept = cyc & stb & ~inject;
        if (!PIPELINED && state_q == ST_RESP) begin
            accept = 1'b0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = accept ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        ack = (state_q == ST_RESP);
    end
endmodule

// File: rtl/wb_sram_slave.sv
module wb_sram_slave #(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 32,
    parameter bit PIPELINED = 1'b0,
    localparam int SEL_W    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_cyc,
    input  logic              wb_stb,
    input  logic              wb_we,
    input  logic [ADDR_W-1:0] wb_adr,
    input  logic [DATA_W-1:0] wb_dat_w,
    input  logic [SEL_W-1:0]  wb_sel,
    input  logic              stall_inject,
    output logic              wb_ack,
    output logic [DATA_W-1:0] wb_dat_r,
    output logic              wb_stall
);
    logic accept;

    sram_resp_fsm #(.PIPELINED(PIPELINED)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cyc    (wb_cyc),
        .stb    (wb_stb),
        .inject (stall_inject),
        .accept (accept),
        .ack    (wb_ack)
    );

    sram_stall_gen #(.PIPELINED(PIPELINED)) u_stall (
        .cyc    (wb_cyc),
        .ack    (wb_ack),
        .inject (stall_inject),
        .stall  (wb_stall)
    );

    sram_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .we     (wb_we),
        .adr    (wb_adr),
        .wdata  (wb_dat_w),
        .sel    (wb_sel),
        .rdata  (wb_dat_r)
    );
endmodule

// File: rtl/wb_sram_slave_chk.sv
module wb_sram_slave_chk #(
    parameter bit PIPELINED = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic cyc,
    input logic stb,
    input logic inject,
    input logic ack,
    input logic stall
);
    // R8: back-pressure blocks acceptance in either style
    a_r8_inject_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        inject |=> !ack);

    generate
        if (PIPELINED) begin : g_pipe_chk
            // R6
            a_r6_stall_only_injected: assert property (@(posedge clk) disable iff (!rst_n)
                !inject |-> !stall);
            // R7
            a_r7_ack_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
                (cyc && stb && !stall) |=> ack);
            // R7: no acknowledge without an accepted request
            a_r7_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
                !(cyc && stb && !stall) |=> !ack);
        end else begin : g_classic_chk
            // R3
            a_r3_no_double_ack: assert property (@(posedge clk) disable iff (!rst_n)
                ack |=> !ack);
            // R4
            a_r4_stall_low_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
                ack |-> !stall);
        end
    endgenerate
endmodule

bind wb_sram_slave wb_sram_slave_chk #(.PIPELINED(PIPELINED)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cyc    (wb_cyc),
    .stb    (wb_stb),
    .inject (stall_inject),
    .ack    (wb_ack),
    .stall  (wb_stall)
);

// File: tb/test_wb_sram_slave.sv
module test_wb_sram_slave;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc = 1'b0, stb = 1'b0, we = 1'b0, inj = 1'b0;
    logic [AW-1:0] adr = '0;
    logic [DW-1:0] dat_w = '0;
    logic [SW-1:0] sel = '0;
    logic          ack_c, stall_c, ack_p, stall_p;
    logic [DW-1:0] dat_c, dat_p;

    int errors = 0;
    int checks = 0;
    bit pipe_phase = 1'b0;
    bit prev_c = 1'b0, prev_p = 1'b0, prev_acc = 1'b0;
    bit finished = 1'b0;
    logic [DW-1:0] mdl [1<<AW];
    logic [DW:0]   q_c [$];
    logic [DW:0]   q_p [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wb_sram_slave #(.ADDR_W(AW), .DATA_W(DW), .PIPELINED(1'b0)) i_wb_sram_slave (
        .clk(clk), .rst_n(rst_n), .wb_cyc(cyc), .wb_stb(stb), .wb_we(we),
        .wb_adr(adr), .wb_dat_w(dat_w), .wb_sel(sel), .stall_inject(inj),
        .wb_ack(ack_c), .wb_dat_r(dat_c), .wb_stall(stall_c));

    wb_sram_slave #(.ADDR_W(AW), .DATA_W(DW), .PIPELINED(1'b1)) i_wb_sram_slave_pipe (
        .clk(clk), .rst_n(rst_n), .wb_cyc(cyc), .wb_stb(stb), .wb_we(we),
        .wb_adr(adr), .wb_dat_w(dat_w), .wb_sel(sel), .stall_inject(inj),
        .wb_ack(ack_p), .wb_dat_r(dat_p), .wb_stall(stall_p));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [SW-1:0] s);
        logic [DW-1:0] r = old_w;
        for (int i = 0; i < SW; i++) if (s[i]) r[i*8 +: 8] = new_w[i*8 +: 8];
        return r;
    endfunction

    // expectation token: bit DW = read, low bits = expected word
    function automatic logic [DW:0] make_tok(input logic w, input logic [AW-1:0] a,
                                             input logic [DW-1:0] d, input logic [SW-1:0] s);
        if (w) begin
            mdl[a] = merge(mdl[a], d, s);
            return {1'b0, {DW{1'b0}}};
        end
        return {1'b1, mdl[a]};
    endfunction

    // scoreboard monitors
    always @(negedge clk) begin
        if (rst_n) begin
            if (!pipe_phase) begin
                if (ack_c) begin
                    logic [DW:0] e;
                    chk(!prev_c, "R3", "ack on consecutive cycles", 1, 0);
                    if (q_c.size() == 0) chk(1'b0, "R2", "unexpected ack", 1, 0);
                    else begin
                        e = q_c.pop_front();
                        if (e[DW]) chk(dat_c == e[DW-1:0], "R2", "classic read data", dat_c, e[DW-1:0]);
                    end
                end
                prev_c = ack_c;
            end else begin
                if (ack_p) begin
                    logic [DW:0] e;
                    if (q_p.size() == 0) chk(1'b0, "R7", "unexpected ack", 1, 0);
                    else begin
                        e = q_p.pop_front();
                        if (e[DW]) chk(dat_p == e[DW-1:0], "R7", "pipelined read data", dat_p, e[DW-1:0]);
                    end
                end
                prev_p = ack_p;
            end
        end
    end

    // classic transfer with optional injected stall cycles before acceptance
    task automatic c_xfer(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [SW-1:0] s, input int inj_cycles);
        @(negedge clk);
        q_c.push_back(make_tok(w, a, d, s));
        cyc = 1; stb = 1; we = w; adr = a; dat_w = d; sel = s;
        inj = (inj_cycles > 0);
        #1 chk(stall_c == 1'b1, "R4", "stall before ack", stall_c, 1);
        for (int n = 0; n < inj_cycles; n++) begin
            @(negedge clk);
            chk(ack_c == 1'b0, "R8", "classic ack under injected stall", ack_c, 0);
            inj = (n + 1 < inj_cycles);
        end
        @(negedge clk);
        chk(ack_c == 1'b1, "R2", "ack one cycle after request", ack_c, 1);
        chk(stall_c == 1'b0, "R4", "stall in ack cycle", stall_c, 0);
        cyc = 0; stb = 0; we = 0; inj = 0;
    endtask

    // classic read with strobe held four cycles
    task automatic c_hold(input logic [AW-1:0] a);
        @(negedge clk);
        q_c.push_back(make_tok(1'b0, a, '0, '0));
        q_c.push_back(make_tok(1'b0, a, '0, '0));
        cyc = 1; stb = 1; we = 0; adr = a; sel = '1;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            chk(ack_c == ((n % 2) == 0), "R3", "held strobe ack pattern", ack_c, ((n % 2) == 0));
        end
        cyc = 0; stb = 0;
    endtask

    // pipelined: one request per cycle; checks previous acceptance's ack
    task automatic p_op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [SW-1:0] s, input logic injv);
        @(negedge clk);
        if (prev_acc) chk(ack_p == 1'b1, "R7", "ack one cycle after accept", ack_p, 1);
        else          chk(ack_p == 1'b0, "R8", "no ack for stalled or absent request", ack_p, 0);
        cyc = 1; stb = 1; we = w; adr = a; dat_w = d; sel = s; inj = injv;
        #1 chk(stall_p == injv, "R6", "pipelined stall", stall_p, injv);
        if (!injv) q_p.push_back(make_tok(w, a, d, s));
        prev_acc = !injv;
    endtask

    task automatic p_idle();
        @(negedge clk);
        if (prev_acc) chk(ack_p == 1'b1, "R7", "ack one cycle after accept", ack_p, 1);
        else          chk(ack_p == 1'b0, "R8", "no ack for stalled request", ack_p, 0);
        cyc = 0; stb = 0; we = 0; inj = 0;
        prev_acc = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ack_c == 1'b0 && ack_p == 1'b0, "R1", "ack during reset", {ack_c, ack_p}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ack_c == 1'b0 && ack_p == 1'b0, "R1", "ack after reset", {ack_c, ack_p}, 0);
        chk(stall_c == 1'b0 && stall_p == 1'b0, "R1", "stall idle", {stall_c, stall_p}, 0);

        // classic phase
        c_xfer(1, 6'd3, 32'h1122_3344, 4'hF, 0);
        c_xfer(0, 6'd3, '0, 4'hF, 0);
        c_xfer(1, 6'd3, 32'hAABB_CCDD, 4'b0101, 0);   // R5 partial lanes
        c_xfer(0, 6'd3, '0, 4'hF, 0);                  // expect 11BB33DD
        chk(mdl[3] == 32'h11BB_33DD, "R5", "bench lane model", mdl[3], 32'h11BB_33DD);
        c_xfer(1, 6'd9, 32'hDEAD_BEEF, 4'hF, 2);       // R8 injected stall
        c_xfer(0, 6'd9, '0, 4'hF, 1);
        c_hold(6'd9);                                  // R3 duplicate-ack guard
        repeat (3) @(negedge clk);
        chk(q_c.size() == 0, "R2", "classic queue drained", q_c.size(), 0);

        // pipelined phase
        pipe_phase = 1'b1;
        p_op(0, 6'd3, '0, 4'hF, 0);
        p_op(0, 6'd9, '0, 4'hF, 0);
        p_op(1, 6'd20, 32'h0BAD_F00D, 4'hF, 0);
        p_op(0, 6'd20, '0, 4'hF, 0);                   // R9 write then read
        p_op(1, 6'd20, 32'h7700_0000, 4'b1000, 0);     // R5 top lane only
        p_op(1, 6'd20, 32'hFFFF_FFFF, 4'hF, 1);        // R8 stalled write, not committed
        p_op(0, 6'd20, '0, 4'hF, 0);                   // expect 77ADF00D
        p_op(0, 6'd3, '0, 4'hF, 1);
        p_op(0, 6'd3, '0, 4'hF, 0);
        p_idle();
        repeat (3) @(negedge clk);
        chk(mdl[20] == 32'h77AD_F00D, "R8", "bench model of stalled write", mdl[20], 32'h77AD_F00D);
        chk(q_p.size() == 0, "R7", "pipelined queue drained", q_p.size(), 0);

        finished = 1'b1;
        summary();
    end
endmodule